// File: doc/BRIEF.md
# Per-Area DMA Read Wait-State Controller

This block sets the length of single-address-mode DMA memory read cycles for eight address areas. It holds a 16-bit control register that software can read and write. A power-on reset loads all ones into it. A separate synchronous manual reset stops any cycle in progress and leaves the register untouched.

When a start strobe arrives while the block is idle, it takes the area number, the area's read-control bit and the 2-bit long-wait count from the long-wait register, and latches them. These choose the number of programmed states in the cycle and whether the active-low WAIT input is sampled.

- If WAIT is sampled, the check happens on the last programmed state. Each low sample adds one more state and repeats the check.
- The cycle ends with a one-clock done pulse on its final state.
- A start strobe is sampled on a rising edge while `busy_o` is low. `busy_o` then rises in the next cycle and stays high for every state of the cycle.

Top module: `dma_rd_wait_ctl`

## Requirements
- R1: After the asynchronous power-on reset `rst_ni`, `reg_rdata_o` reads 0xFFFF and `busy_o` and `done_o` are low.
- R2: A write (`reg_we_i` high at a rising edge) loads `reg_wdata_i` into the register, and `reg_rdata_o` shows it from the next cycle. Bit 8+n is the read control for area n (n = 0..7). The low byte is stored and read back but has no effect on read timing.
- R3: `soft_rst_i` high at a rising edge drops `busy_o` in the next cycle and leaves the register value unchanged.
- R4: For areas 1, 3, 4, 5 and 7 with a clear read-control bit, the cycle lasts one state whatever the level of `wait_ni`. For area 1 this is the short-pitch column phase.
- R5: For areas 1, 3, 4, 5 and 7 with a set read-control bit, the cycle lasts two states plus one state for each low WAIT sample. For area 1 this is the long-pitch column phase.
- R6: For areas 0 and 2 with a clear read-control bit, the cycle lasts 1 + `long_wait_i` states and WAIT is ignored.
- R7: For areas 0 and 2 with a set read-control bit, the cycle lasts 1 + `long_wait_i` states plus one state for each low WAIT sample.
- R8: For area 6 the cycle lasts four states plus one state for each low WAIT sample, whatever its read-control bit holds.
- R9: WAIT is sampled only on the last programmed state and on the states it adds. A low level in earlier states has no effect, and the cycle ends on the first state in which WAIT is sampled high.
- R10: The area, the control bit and `long_wait_i` are latched at start. Changing them, or writing the register, during a cycle does not alter that cycle.
- R11: `done_o` is high for exactly one clock, on the final busy state. `busy_o` is low in the following cycle. A start strobe while busy is ignored, and a strobe in the cycle after done is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| soft_rst_i | input | 1 | Synchronous manual reset; register kept |
| reg_we_i | input | 1 | Register write enable |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| start_i | input | 1 | Cycle start strobe |
| area_i | input | 3 | Area number of the cycle |
| long_wait_i | input | 2 | Long-wait state count for areas 0 and 2 |
| wait_ni | input | 1 | Active-low external WAIT |
| busy_o | output | 1 | High during every state of a read cycle |
| done_o | output | 1 | One-clock pulse on the final state |

## Verification
The bench drives WAIT low in states before the last programmed one. A design that sampled WAIT too early would lengthen those cycles, and one that ignored the extra samples would end area 6 cycles at four states. It changes the long-wait count and rewrites the register in the middle of a cycle, which catches a design that reads these live instead of latching them. It also issues start strobes while busy and in the cycle right after done, which exposes an accept window that is off by one. Finally, it asserts the manual reset during a cycle, which catches a design that clears the register or keeps counting.

// File: rtl/dma_wait_pkg.sv
package dma_wait_pkg;

  typedef enum logic [1:0] {
    CLS_FAST  = 2'd0,
    CLS_LONG  = 2'd1,
    CLS_DRAM  = 2'd2,
    CLS_MUXIO = 2'd3
  } area_cls_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_st_e;

  function automatic area_cls_e area_class(int unsigned idx);
    case (idx)
      0, 2:    return CLS_LONG;
      1:       return CLS_DRAM;
      6:       return CLS_MUXIO;
      default: return CLS_FAST;
    endcase
  endfunction

endpackage

// File: rtl/wait_ctl_reg.sv
module wait_ctl_reg #(
  parameter int REG_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] q_o
);
  // power-on reset only; manual reset never reaches this register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '1;
    else if (we_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/area_timing_decode.sv
module area_timing_decode
  import dma_wait_pkg::*;
#(
  parameter int NUM_AREAS = 8,
  parameter int LW_W      = 2,
  parameter int MUX_LEN   = 4,
  parameter int LEN_W     = 3,
  localparam int AREA_W   = $clog2(NUM_AREAS)
) (
  input  logic [AREA_W-1:0]    area_i,
  input  logic [NUM_AREAS-1:0] rd_ctl_i,
  input  logic [LW_W-1:0]      long_wait_i,
  output logic [LEN_W-1:0]     len_o,
  output logic                 samp_o
);
  logic [LEN_W-1:0] len_a  [NUM_AREAS];
  logic             samp_a [NUM_AREAS];

  for (genvar g = 0; g < NUM_AREAS; g++) begin : g_area
    localparam area_cls_e CLS = area_class(g);
    if (CLS == CLS_MUXIO) begin : g_mux
      assign len_a[g]  = LEN_W'(MUX_LEN);
      assign samp_a[g] = 1'b1;
    end else if (CLS == CLS_LONG) begin : g_long
      assign len_a[g]  = LEN_W'(1) + LEN_W'(long_wait_i);
      assign samp_a[g] = rd_ctl_i[g];
    end else begin : g_short
      // plain areas and DRAM column phase: short or long pitch
      assign len_a[g]  = rd_ctl_i[g] ? LEN_W'(2) : LEN_W'(1);
      assign samp_a[g] = rd_ctl_i[g];
    end
  end

  assign len_o  = len_a[area_i];
  assign samp_o = samp_a[area_i];
endmodule

// File: rtl/read_cycle_seq.sv
module read_cycle_seq
  import dma_wait_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             start_i,
  input  logic             wait_ni,
  input  logic [LEN_W-1:0] len_i,
  input  logic             samp_i,
  output logic             busy_o,
  output logic             done_o
);
  seq_st_e          st_q;
  logic [LEN_W-1:0] cnt_q, len_q;
  logic             samp_q;
  logic             at_last, hold;

  assign at_last = (cnt_q == len_q);
  assign hold    = at_last && samp_q && !wait_ni;
  assign busy_o  = (st_q == SEQ_RUN);
  assign done_o  = busy_o && at_last && !hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SEQ_IDLE;
      cnt_q  <= '0;
      len_q  <= '0;
      samp_q <= 1'b0;
    end else if (soft_rst_i) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        SEQ_IDLE: if (start_i) begin
          st_q   <= SEQ_RUN;
          cnt_q  <= LEN_W'(1);
          len_q  <= len_i;
          samp_q <= samp_i;
        end
        SEQ_RUN: begin
          if (done_o)        st_q  <= SEQ_IDLE;
          else if (!at_last) cnt_q <= cnt_q + LEN_W'(1);
        end
        default: st_q <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_rd_wait_ctl.sv
module dma_rd_wait_ctl
  import dma_wait_pkg::*;
#(
  parameter int NUM_AREAS = 8,
  parameter int LW_W      = 2,
  parameter int MUX_LEN   = 4,
  localparam int REG_W    = 2 * NUM_AREAS,
  localparam int AREA_W   = $clog2(NUM_AREAS),
  localparam int LW_MAX   = 1 << LW_W,
  localparam int MAX_LEN  = (MUX_LEN > LW_MAX) ? MUX_LEN : LW_MAX,
  localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              start_i,
  input  logic [AREA_W-1:0] area_i,
  input  logic [LW_W-1:0]   long_wait_i,
  input  logic              wait_ni,
  output logic              busy_o,
  output logic              done_o
);
  logic [REG_W-1:0] ctl_q;
  logic [LEN_W-1:0] len;
  logic             samp;

  wait_ctl_reg #(.REG_W(REG_W)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .q_o     (ctl_q)
  );

  area_timing_decode #(
    .NUM_AREAS (NUM_AREAS),
    .LW_W      (LW_W),
    .MUX_LEN   (MUX_LEN),
    .LEN_W     (LEN_W)
  ) u_dec (
    .area_i      (area_i),
    .rd_ctl_i    (ctl_q[REG_W-1:NUM_AREAS]),
    .long_wait_i (long_wait_i),
    .len_o       (len),
    .samp_o      (samp)
  );

  read_cycle_seq #(.LEN_W(LEN_W)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .start_i    (start_i),
    .wait_ni    (wait_ni),
    .len_i      (len),
    .samp_i     (samp),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  assign reg_rdata_o = ctl_q;
endmodule

// File: rtl/dma_rd_wait_ctl_chk.sv
module dma_rd_wait_ctl_chk
  import dma_wait_pkg::*;
#(
  parameter int NUM_AREAS = 8,
  localparam int REG_W    = 2 * NUM_AREAS,
  localparam int AREA_W   = $clog2(NUM_AREAS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              reg_we_i,
  input logic              start_i,
  input logic [AREA_W-1:0] area_i,
  input logic [REG_W-1:0]  reg_rdata_o,
  input logic              busy_o,
  input logic              done_o
);
  function automatic logic short_area(logic [AREA_W-1:0] a);
    area_class_check: begin end
    return (area_class(int'(a)) == CLS_FAST) || (area_class(int'(a)) == CLS_DRAM);
  endfunction

  a_r11_done_one_wide: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_done_in_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  a_r11_idle_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  a_r11_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && !soft_rst_i) |=> busy_o);

  a_r3_soft_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !busy_o);

  a_r3_reg_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (soft_rst_i && !reg_we_i) |=> $stable(reg_rdata_o));

  a_r4_one_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !soft_rst_i && short_area(area_i) &&
     !reg_rdata_o[NUM_AREAS + int'(area_i)]) |=> done_o);

  a_r8_mux_not_short: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && !soft_rst_i && area_class(int'(area_i)) == CLS_MUXIO)
    |=> (busy_o && !done_o));
endmodule

bind dma_rd_wait_ctl dma_rd_wait_ctl_chk #(.NUM_AREAS(NUM_AREAS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .soft_rst_i  (soft_rst_i),
  .reg_we_i    (reg_we_i),
  .start_i     (start_i),
  .area_i      (area_i),
  .reg_rdata_o (reg_rdata_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/dma_rd_wait_ctl_test.sv
module dma_rd_wait_ctl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        soft_rst = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        start = 1'b0;
  logic [2:0]  area = '0;
  logic [1:0]  lw = '0;
  logic        wait_n = 1'b1;
  logic        busy, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  dma_rd_wait_ctl uut (
    .clk_i(clk), .rst_ni(rst_ni), .soft_rst_i(soft_rst),
    .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .start_i(start), .area_i(area), .long_wait_i(lw), .wait_ni(wait_n),
    .busy_o(busy), .done_o(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  logic [15:0] m_reg  = 16'hFFFF;
  bit          m_busy = 1'b0;
  bit          m_samp = 1'b0;
  int          m_cnt  = 0;
  int          m_len  = 0;
  string       m_tag  = "R1";
  string       m_rtag = "R1";

  function automatic int ref_len(int a, bit b, int l);
    if (a == 6)           return 4;
    if (a == 0 || a == 2) return 1 + l;
    return b ? 2 : 1;
  endfunction

  function automatic string ref_tag(int a, bit b);
    if (a == 6)           return "R8 R9 R10 R11";
    if (a == 0 || a == 2) return b ? "R7 R9 R10 R11" : "R6 R10 R11";
    return b ? "R5 R9 R10 R11" : "R4 R10 R11";
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_ni) begin
      m_reg = 16'hFFFF; m_busy = 1'b0; m_cnt = 0; m_tag = "R1"; m_rtag = "R1";
    end else if (!finished) begin
      bit exp_done;
      exp_done = m_busy && (m_cnt == m_len) && !(m_samp && !wait_n);
      chk(m_tag,  "busy",  {15'd0, busy},  {15'd0, m_busy});
      chk(m_tag,  "done",  {15'd0, done},  {15'd0, exp_done});
      chk(m_rtag, "rdata", rdata, m_reg);
      if (soft_rst) begin
        m_busy = 1'b0; m_tag = "R3"; m_rtag = "R3";
      end else if (m_busy) begin
        if (exp_done) begin m_busy = 1'b0; m_tag = "R11"; end
        else if (m_cnt < m_len) m_cnt++;
      end else if (start) begin
        bit b;
        b      = m_reg[8 + int'(area)];
        m_len  = ref_len(int'(area), b, int'(lw));
        m_samp = (area == 3'd6) ? 1'b1 : b;
        m_cnt  = 1;
        m_busy = 1'b1;
        m_tag  = ref_tag(int'(area), b);
      end
      if (we) begin m_reg = wdata; m_rtag = "R2"; end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic launch(logic [2:0] a, logic [1:0] l);
    start = 1'b1; area = a; lw = l;
    step(1);
    start = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(3);                         // R1 reset value observed by model
    // all controls clear, WAIT held low: R4, R6 ignore it
    we = 1'b1; wdata = 16'h0000; step(1); we = 1'b0;
    for (int a = 0; a < 8; a++) begin
      wait_n = 1'b0;
      launch(3'(a), 2'(a % 4));
      step(3);
      wait_n = 1'b1;
      step(4);
    end
    // all read controls set, WAIT low briefly early and late: R5 R7 R8 R9
    we = 1'b1; wdata = 16'hFF5A; step(1); we = 1'b0;
    for (int a = 0; a < 8; a++) begin
      launch(3'(a), 2'((a + 1) % 4));
      wait_n = 1'b0; step(2);
      wait_n = 1'b1; step(1);
      wait_n = 1'b0; step(2);
      wait_n = 1'b1; step(4);
    end
    // mid-cycle changes of long-wait and register: R10
    launch(3'd0, 2'd3);
    lw = 2'd0; we = 1'b1; wdata = 16'h0000; step(1); we = 1'b0;
    step(6);
    launch(3'd6, 2'd0);
    we = 1'b1; wdata = 16'hFFFF; area = 3'd1; step(1); we = 1'b0;
    step(6);
    // start while busy, then back-to-back after done: R11
    launch(3'd2, 2'd3);
    start = 1'b1; area = 3'd7; step(3);
    step(3); start = 1'b0; step(4);
    // manual reset mid-cycle: R3
    launch(3'd6, 2'd0);
    step(1);
    soft_rst = 1'b1; step(1); soft_rst = 1'b0;
    step(3);
    // mixed traffic
    for (int i = 0; i < 6000; i++) begin
      start    = ($urandom_range(0, 99) < 50);
      area     = 3'($urandom_range(0, 7));
      lw       = 2'($urandom_range(0, 3));
      wait_n   = ($urandom_range(0, 99) >= 30);
      we       = ($urandom_range(0, 99) < 5);
      wdata    = 16'($urandom);
      soft_rst = ($urandom_range(0, 99) < 2);
      step(1);
    end
    start = 1'b0; we = 1'b0; soft_rst = 1'b0; wait_n = 1'b1;
    step(8);
    finish_run();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule